// File: doc/BRIEF.md
# Dual-Rail Wavefront AND Stage

This block is a clocked, cycle-level model of one self-timed logic stage that works on dual-rail coded data. Two operand vectors, each made of `WIDTH` dual-rail bits, enter the stage. Each result bit is the logical AND of the matching operand bits. Every result bit is built from four hysteresis threshold cells. A cell sets when both of its inputs are high. It clears only when both are low. In every other case it keeps its value.

Because of this hysteresis, a result bit does not move from the spacer code (NULL) to a data code until both operand bits carry data. It does not return to NULL until both operand bits have gone back to NULL. The order and skew in which the rails arrive therefore do not change the result.

A two-state phase tracker watches the whole result vector and drives a completion output. Its states are `PH_NULL` and `PH_DATA`. The transition `PH_NULL -> PH_DATA` is taken when every result bit holds data. The transition `PH_DATA -> PH_NULL` is taken when every result bit is NULL. In any other case the tracker stays in its current state. A sticky guard flags the forbidden code on any operand or result bit. Upstream logic uses `done` as the stage's acknowledge, for the data wave and for the spacer wave.

Top module: `dr_and_stage`

## Requirements
- R1: Dual-rail bit `i` occupies bits [2i+1:2i] of a vector. Bit 2i+1 is the true rail and bit 2i is the false rail. Code 2'b10 means logic 1, 2'b01 means logic 0, 2'b00 is NULL and 2'b11 is forbidden.
- R2: While `rst` is high at a clock edge, every threshold cell clears. After that edge, `res` is all NULL, `done` is 0 and `illegal` is 0.
- R3: A result bit that is NULL changes to a data code on the first clock edge at which both of its operand bits hold data codes.
- R4: A result bit that holds data returns to NULL on the first clock edge at which both of its operand bits are NULL.
- R5: A result bit that takes a data code is 2'b10 when both operand bits are 2'b10, and 2'b01 otherwise.
- R6: While exactly one of a result bit's two operand bits holds data, that result bit keeps its previous code.
- R7: `done` rises one clock after every result bit holds data. It falls one clock after every result bit is NULL. Otherwise it keeps its value.
- R8: `illegal` goes high one clock after any operand or result bit shows 2'b11. It then stays high until reset.
- R9: The result does not depend on the order or number of cycles in which the individual operand bits arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 2*WIDTH | First dual-rail operand vector |
| op_b | input | 2*WIDTH | Second dual-rail operand vector |
| res | output | 2*WIDTH | Dual-rail AND result, taken from the threshold cells |
| done | output | 1 | Completion: high in the data phase, low in the NULL phase |
| illegal | output | 1 | Sticky flag for a forbidden code |

## Verification
A threshold cell that is stuck, that sets too early or that fails to hold shows up on `res` at the very next clock edge. The bench checks this by comparing `res` on every cycle against a behavioural model of the set, clear and hold rule. Operand bits arrive with random skew, so many cycles have only one operand of a pair in data. These are exactly the cycles where a missing hysteresis term becomes visible. A phase tracker that takes the wrong transition is exposed one cycle later on `done`. A guard that forgets its history is exposed on `illegal` on the first cycle after the forbidden code is removed.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef logic [1:0] dr_t;

    localparam dr_t DR_NULL = 2'b00;
    localparam dr_t DR_ZERO = 2'b01;
    localparam dr_t DR_ONE  = 2'b10;
    localparam dr_t DR_BAD  = 2'b11;

    typedef enum logic {
        PH_NULL = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    function automatic logic is_data(input dr_t c);
        return (c == DR_ZERO) || (c == DR_ONE);
    endfunction

    function automatic logic is_null(input dr_t c);
        return c == DR_NULL;
    endfunction

endpackage

// File: rtl/th22_cell.sv
module th22_cell (
    input  logic clk,
    input  logic rst,
    input  logic x,
    input  logic y,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= (x & y) | (q & (x | y));
        end
    end

    // R3: both inputs high sets the cell
    a_r3_cell_set: assert property (@(posedge clk) disable iff (rst)
        (x && y) |=> q);

    // R4: both inputs low clears the cell
    a_r4_cell_clear: assert property (@(posedge clk) disable iff (rst)
        (!x && !y) |=> !q);

    // R6: inputs disagree, so the cell keeps its value
    a_r6_cell_hold: assert property (@(posedge clk) disable iff (rst)
        (x != y) |=> (q == $past(q)));

endmodule

// File: rtl/dr_and_bit.sv
module dr_and_bit
    import dr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  dr_t  a,
    input  dr_t  b,
    output dr_t  z
);

    localparam int NCELL = 4;

    // cell k joins rail a[k[1]] with rail b[k[0]]; only k=3 is the true-true pair
    logic [NCELL-1:0] hit;

    genvar k;
    generate
        for (k = 0; k < NCELL; k++) begin : g_cell
            localparam int RA = k / 2;
            localparam int RB = k % 2;
            th22_cell u_th (
                .clk (clk),
                .rst (rst),
                .x   (a[RA]),
                .y   (b[RB]),
                .q   (hit[k])
            );
        end
    endgenerate

    assign z = {hit[NCELL-1], |hit[NCELL-2:0]};

    // R5: a true result requires both operands true at the previous edge
    a_r5_true_needs_both: assert property (@(posedge clk) disable iff (rst)
        ($rose(z[1]) |-> ($past(a) == DR_ONE && $past(b) == DR_ONE)));

endmodule

// File: rtl/phase_tracker.sv
module phase_tracker
    import dr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2*WIDTH-1:0] res,
    output logic               done
);

    phase_e state_q, state_d;
    logic   all_data, all_null;

    always_comb begin
        all_data = 1'b1;
        all_null = 1'b1;
        for (int i = 0; i < WIDTH; i++) begin
            all_data = all_data & is_data(res[2*i +: 2]);
            all_null = all_null & is_null(res[2*i +: 2]);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_NULL: if (all_data) state_d = PH_DATA;
            PH_DATA: if (all_null) state_d = PH_NULL;
            default: state_d = PH_NULL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_NULL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            PH_DATA: done = 1'b1;
            default: done = 1'b0;
        endcase
    end

    // R7: complete data wave raises completion next cycle
    a_r7_rise: assert property (@(posedge clk) disable iff (rst)
        all_data |=> done);

    // R7: complete spacer wave drops completion next cycle
    a_r7_fall: assert property (@(posedge clk) disable iff (rst)
        all_null |=> !done);

endmodule

// File: rtl/code_guard.sv
module code_guard
    import dr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2*WIDTH-1:0] op_a,
    input  logic [2*WIDTH-1:0] op_b,
    input  logic [2*WIDTH-1:0] res,
    output logic               illegal
);

    logic seen_bad;

    always_comb begin
        seen_bad = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            seen_bad = seen_bad | (op_a[2*i +: 2] == DR_BAD)
                                | (op_b[2*i +: 2] == DR_BAD)
                                | (res[2*i +: 2]  == DR_BAD);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            illegal <= 1'b0;
        end else if (seen_bad) begin
            illegal <= 1'b1;
        end
    end

    // R8: flag is sticky until reset
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        illegal |=> illegal);

    // R8: forbidden code raises the flag next cycle
    a_r8_detect: assert property (@(posedge clk) disable iff (rst)
        seen_bad |=> illegal);

endmodule

// File: rtl/dr_and_stage.sv
module dr_and_stage
    import dr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2*WIDTH-1:0] op_a,
    input  logic [2*WIDTH-1:0] op_b,
    output logic [2*WIDTH-1:0] res,
    output logic               done,
    output logic               illegal
);

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            dr_and_bit u_bit (
                .clk (clk),
                .rst (rst),
                .a   (op_a[2*i +: 2]),
                .b   (op_b[2*i +: 2]),
                .z   (res[2*i +: 2])
            );
        end
    endgenerate

    phase_tracker #(.WIDTH(WIDTH)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .res  (res),
        .done (done)
    );

    code_guard #(.WIDTH(WIDTH)) u_guard (
        .clk     (clk),
        .rst     (rst),
        .op_a    (op_a),
        .op_b    (op_b),
        .res     (res),
        .illegal (illegal)
    );

    // R2: reset leaves the result at NULL
    a_r2_reset_null: assert property (@(posedge clk)
        rst |=> (res == '0));

endmodule

// File: tb/dr_and_stage_test.sv
`timescale 1ns/1ps
module dr_and_stage_test;

    localparam int WIDTH = 4;
    localparam int NW    = 2 * WIDTH;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NW-1:0] op_a = '0;
    logic [NW-1:0] op_b = '0;
    logic [NW-1:0] res;
    logic          done;
    logic          illegal;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    dr_and_stage #(.WIDTH(WIDTH)) uut (
        .clk     (clk),
        .rst     (rst),
        .op_a    (op_a),
        .op_b    (op_b),
        .res     (res),
        .done    (done),
        .illegal (illegal)
    );

    // reference state: result codes, phase, sticky flag
    logic [1:0] m_res [WIDTH];
    logic       m_done = 1'b0;
    logic       m_ill  = 1'b0;

    function automatic logic dat(input logic [1:0] c);
        return (c == 2'b01) || (c == 2'b10);
    endfunction

    task automatic check(input string tag, input logic [NW-1:0] act, input logic [NW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle reference model, compared after every edge
    always begin
        logic [NW-1:0] ia, ib;
        logic          rs;
        logic [1:0]    old [WIDTH];
        logic          alld, alln, badc;
        @(posedge clk);
        ia = op_a; ib = op_b; rs = rst;
        for (int i = 0; i < WIDTH; i++) old[i] = m_res[i];
        if (rs) begin
            for (int i = 0; i < WIDTH; i++) m_res[i] = 2'b00;
            m_done = 1'b0;
            m_ill  = 1'b0;
        end else begin
            alld = 1'b1; alln = 1'b1; badc = 1'b0;
            for (int i = 0; i < WIDTH; i++) begin
                alld &= dat(old[i]);
                alln &= (old[i] == 2'b00);
                badc |= (ia[2*i +: 2] == 2'b11) | (ib[2*i +: 2] == 2'b11) | (old[i] == 2'b11);
            end
            if (alld) m_done = 1'b1;
            else if (alln) m_done = 1'b0;
            if (badc) m_ill = 1'b1;
            for (int i = 0; i < WIDTH; i++) begin
                logic [1:0] a2, b2;
                a2 = ia[2*i +: 2]; b2 = ib[2*i +: 2];
                if (dat(a2) && dat(b2) && old[i] == 2'b00)
                    m_res[i] = (a2 == 2'b10 && b2 == 2'b10) ? 2'b10 : 2'b01;
                else if (a2 == 2'b00 && b2 == 2'b00)
                    m_res[i] = 2'b00;
            end
        end
        #1;
        for (int i = 0; i < WIDTH; i++) begin
            if (rs) check("R2 result", {6'd0, res[2*i +: 2]}, {6'd0, m_res[i]});
            else if (old[i] == 2'b00 && m_res[i] != 2'b00) begin
                // R9: arrival skew is random, so this also covers ordering
                check("R3 R9 rise", {6'd0, res[2*i +: 2]}, {6'd0, m_res[i]});
                check("R1 R5 value",
                      {7'd0, res[2*i+1]},
                      {7'd0, (ia[2*i +: 2] == 2'b10) && (ib[2*i +: 2] == 2'b10)});
            end else if (old[i] != 2'b00 && m_res[i] == 2'b00)
                check("R4 fall", {6'd0, res[2*i +: 2]}, {6'd0, m_res[i]});
            else
                check("R6 hold", {6'd0, res[2*i +: 2]}, {6'd0, m_res[i]});
        end
        check(rs ? "R2 done" : "R7 done", {7'd0, done}, {7'd0, m_done});
        check(rs ? "R2 illegal" : "R8 illegal", {7'd0, illegal}, {7'd0, m_ill});
    end

    // one wavefront with random per-bit arrival cycle
    task automatic wave(input bit to_data);
        int         da [WIDTH];
        int         db [WIDTH];
        logic [1:0] ta [WIDTH];
        logic [1:0] tb [WIDTH];
        for (int i = 0; i < WIDTH; i++) begin
            da[i] = $urandom_range(0, 4);
            db[i] = $urandom_range(0, 4);
            ta[i] = to_data ? ($urandom_range(0, 1) ? 2'b10 : 2'b01) : 2'b00;
            tb[i] = to_data ? ($urandom_range(0, 1) ? 2'b10 : 2'b01) : 2'b00;
        end
        for (int c = 0; c <= 4; c++) begin
            @(negedge clk);
            for (int i = 0; i < WIDTH; i++) begin
                if (da[i] == c) op_a[2*i +: 2] = ta[i];
                if (db[i] == c) op_b[2*i +: 2] = tb[i];
            end
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < WIDTH; i++) m_res[i] = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // main function: alternating data and spacer waves
        for (int w = 0; w < 80; w++) wave((w % 2) == 0);
        // R8: forbidden code on an operand while the other is NULL
        @(negedge clk);
        op_a[1:0] = 2'b11;
        @(negedge clk);
        op_a[1:0] = 2'b00;
        repeat (3) @(negedge clk);
        check("R8 sticky after removal", {7'd0, illegal}, 8'd1);
        // R2: reset clears the flag
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R2 flag cleared", {7'd0, illegal}, 8'd0);
        for (int w = 0; w < 6; w++) wave((w % 2) == 0);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule